// File: doc/BRIEF.md
# Timer PWM with Deadband and Kill

This block is a 16-bit up-counting timer that produces a complementary pair of PWM outputs for a half-bridge style driver. The count runs from zero up to a programmable period. It then wraps to zero or stops, depending on a mode bit. A compare register sets the duty cycle. A capture input stores the current count together with a valid flag and an overflow flag.

Each of the two outputs has a programmable dead time applied to its rising edge. Because of this, one output switches off before the other switches on. A kill input overrides both pins with programmed safe levels in the same cycle that it is asserted. The override then stays in force until kill is low and a new period starts.

Software configures the block through a simple register write port. The addresses are: 0 period, 1 compare, 2 dead time (bits 7:0), 3 control, 4 safe levels.

Top module: `pwm_dt_timer`

## Requirements
- R1: After reset the count is 0 and the run flag is 0. No capture is valid and no overflow is flagged. The kill override is active, so both PWM pins show the safe levels, which reset to 0.
- R2: While running, the count rises by one per clock. While running with count equal to period, tc_o is high. In reload mode the next count is 0. A period of 0 therefore gives tc_o high on every cycle.
- R3: In stop mode (control bit 1 = 1), reaching the period holds the count at the period value and clears the run flag.
- R4: A capture event stores the count from the cycle of the event and sets cap_valid_o. A cap_rd_i pulse with no event clears cap_valid_o and cap_ovf_o.
- R5: A capture event while cap_valid_o is high and cap_rd_i is low sets cap_ovf_o. The new count is still stored.
- R6: The raw PWM level is high while count < compare. A compare value above the period gives a constant high.
- R7: Each output rises only after its source (raw level for pwm_o, its inverse for pwm_n_o) has been high for the dead time in cycles (0 to 255). Each output falls in the same cycle as its source.
- R8: While no kill override is active, pwm_o and pwm_n_o are never high together.
- R9: While kill_i is high, pwm_o equals safe bit 0 and pwm_n_o equals safe bit 1 in that same cycle, with no register in the path.
- R10: The override stays active after kill_i falls. It is released only by a period start: a reload wrap, or a control write with the clear bit set.
- R11: A control write sets run from bit 0 and stop mode from bit 1. The count does not advance in that cycle. If bit 2 is set, the count is zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| cap_evt_i | input | 1 | Capture event, one per high cycle |
| cap_rd_i | input | 1 | Acknowledges the capture value |
| kill_i | input | 1 | Forces outputs to safe levels |
| pwm_o | output | 1 | True PWM output |
| pwm_n_o | output | 1 | Complementary PWM output |
| count_o | output | 16 | Current count |
| cap_val_o | output | 16 | Captured count |
| cap_valid_o | output | 1 | Unread capture present |
| cap_ovf_o | output | 1 | Capture overwritten before read |
| run_o | output | 1 | Counter running |
| tc_o | output | 1 | Count equals period while running |
| kill_act_o | output | 1 | Kill override in force |

## Verification
The bench targets a zero period, where a wrap on every cycle would be missed by a design that increments before it compares. It drives a compare value above the period, which a design comparing against the period instead would turn into a short low pulse. It releases kill in the middle of a period; an override that dropped with the pin would let the outputs glitch to live values before the wrap. It also issues back-to-back captures without a read, which exposes a missing overflow flag. Changes to the dead time while the counter runs show any rising edge that comes too early, or any falling edge that is held back.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERIOD = 3'd0,
    REG_CMP    = 3'd1,
    REG_DEAD   = 3'd2,
    REG_CTRL   = 3'd3,
    REG_SAFE   = 3'd4
  } reg_addr_e;

  localparam int unsigned CTRL_RUN  = 0;
  localparam int unsigned CTRL_STOP = 1;
  localparam int unsigned CTRL_CLR  = 2;

  localparam int unsigned N_CH = 2;
endpackage

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             run_set_i,
  input  logic             clr_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             tc_o,
  output logic             period_start_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             at_end;

  assign at_end = (cnt_q == period_i);
  assign tc_o   = run_q && at_end;
  assign period_start_o = (ctrl_wr_i && clr_i) ||
                          (!ctrl_wr_i && tc_o && !stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (ctrl_wr_i) begin
      run_q <= run_set_i;
      if (clr_i) cnt_q <= '0;
    end else if (run_q) begin
      if (at_end) begin
        if (stop_i) run_q <= 1'b0;
        else        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/tpwm_capture.sv
module tpwm_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] val_o,
  output logic             valid_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] val_q;
  logic             valid_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (evt_i) val_q <= cnt_i;
      valid_q <= evt_i || (valid_q && !rd_i);
      // overwrite of an unread value, cleared by the read
      ovf_q   <= !rd_i && (ovf_q || (evt_i && valid_q));
    end
  end

  assign val_o   = val_q;
  assign valid_o = valid_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/tpwm_deadband.sv
module tpwm_deadband #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            out_o
);
  logic [DT_W-1:0] hold_q;

  // cycles the source has been high, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_q <= '0;
    else if (!in_i)             hold_q <= '0;
    else if (hold_q != '1)      hold_q <= hold_q + 1'b1;
  end

  assign out_o = in_i && (hold_q >= dt_i);
endmodule

// File: rtl/pwm_dt_timer.sv
module pwm_dt_timer
  import tpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              cap_evt_i,
  input  logic              cap_rd_i,
  input  logic              kill_i,
  output logic              pwm_o,
  output logic              pwm_n_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  cap_val_o,
  output logic              cap_valid_o,
  output logic              cap_ovf_o,
  output logic              run_o,
  output logic              tc_o,
  output logic              kill_act_o
);
  logic [CNT_W-1:0] prd_q, cmp_q;
  logic [DT_W-1:0]  dt_q;
  logic [N_CH-1:0]  safe_q;
  logic             stop_q, kill_q;
  logic             ctrl_wr, period_start, raw;
  logic [N_CH-1:0]  db_in, db_out;
  logic [CNT_W-1:0] cnt;

  assign ctrl_wr = wr_en_i && (wr_addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q  <= '0;
      cmp_q  <= '0;
      dt_q   <= '0;
      safe_q <= '0;
      stop_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        REG_PERIOD: prd_q  <= wr_data_i;
        REG_CMP:    cmp_q  <= wr_data_i;
        REG_DEAD:   dt_q   <= wr_data_i[DT_W-1:0];
        REG_CTRL:   stop_q <= wr_data_i[CTRL_STOP];
        REG_SAFE:   safe_q <= wr_data_i[N_CH-1:0];
        default: ;
      endcase
    end
  end

  tpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_wr_i      (ctrl_wr),
    .run_set_i      (wr_data_i[CTRL_RUN]),
    .clr_i          (wr_data_i[CTRL_CLR]),
    .stop_i         (stop_q),
    .period_i       (prd_q),
    .cnt_o          (cnt),
    .run_o          (run_o),
    .tc_o           (tc_o),
    .period_start_o (period_start)
  );

  tpwm_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (cap_evt_i),
    .rd_i    (cap_rd_i),
    .cnt_i   (cnt),
    .val_o   (cap_val_o),
    .valid_o (cap_valid_o),
    .ovf_o   (cap_ovf_o)
  );

  assign raw   = (cnt < cmp_q);
  assign db_in = {~raw, raw};

  for (genvar g = 0; g < N_CH; g++) begin : g_db
    tpwm_deadband #(.DT_W(DT_W)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (db_in[g]),
      .dt_i   (dt_q),
      .out_o  (db_out[g])
    );
  end

  // override held from reset until the first period start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           kill_q <= 1'b1;
    else if (kill_i)       kill_q <= 1'b1;
    else if (period_start) kill_q <= 1'b0;
  end

  assign kill_act_o = kill_i || kill_q;
  assign pwm_o      = kill_act_o ? safe_q[0] : db_out[0];
  assign pwm_n_o    = kill_act_o ? safe_q[1] : db_out[1];
  assign count_o    = cnt;
endmodule

// File: rtl/tpwm_checker.sv
module tpwm_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic             cap_evt_i,
  input logic             cap_rd_i,
  input logic             kill_i,
  input logic             pwm_o,
  input logic             pwm_n_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_valid_o,
  input logic             cap_ovf_o,
  input logic             run_o,
  input logic             tc_o,
  input logic             kill_act_o,
  input logic             stop_q,
  input logic [1:0]       safe_q
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (wr_addr_i == 3'd3);

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && !tc_o && !ctrl_wr |=> count_o == CNT_W'($past(count_o) + 1'b1));

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o && !stop_q && !ctrl_wr |=> count_o == '0);

  p_stop_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o && stop_q && !ctrl_wr |=> !run_o && $stable(count_o));

  p_cap_val_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> cap_valid_o && cap_val_o == $past(count_o));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i && cap_valid_o && !cap_rd_i |=> cap_ovf_o);

  p_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kill_act_o |-> !(pwm_o && pwm_n_o));

  p_kill_now_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |-> pwm_o == safe_q[0] && pwm_n_o == safe_q[1]);

  p_kill_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> kill_act_o);
endmodule

bind pwm_dt_timer tpwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .cap_evt_i   (cap_evt_i),
  .cap_rd_i    (cap_rd_i),
  .kill_i      (kill_i),
  .pwm_o       (pwm_o),
  .pwm_n_o     (pwm_n_o),
  .count_o     (count_o),
  .cap_val_o   (cap_val_o),
  .cap_valid_o (cap_valid_o),
  .cap_ovf_o   (cap_ovf_o),
  .run_o       (run_o),
  .tc_o        (tc_o),
  .kill_act_o  (kill_act_o),
  .stop_q      (stop_q),
  .safe_q      (safe_q)
);

// File: tb/pwm_dt_timer_tb_top.sv
module pwm_dt_timer_tb_top;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        cap_evt_i = 1'b0, cap_rd_i = 1'b0, kill_i = 1'b0;
  logic        pwm_o, pwm_n_o, cap_valid_o, cap_ovf_o, run_o, tc_o, kill_act_o;
  logic [15:0] count_o, cap_val_o;

  int checks = 0, errors = 0;
  bit chk_en = 1'b0;

  // reference model state
  int m_prd, m_cmp, m_dt, m_safe, m_cnt, m_capv, m_len_t, m_len_c;
  bit m_run, m_stop, m_valid, m_ovf, m_killq;

  always #(CLK_NS/2) clk = ~clk;

  pwm_dt_timer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cap_evt_i(cap_evt_i), .cap_rd_i(cap_rd_i),
    .kill_i(kill_i), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o), .count_o(count_o),
    .cap_val_o(cap_val_o), .cap_valid_o(cap_valid_o), .cap_ovf_o(cap_ovf_o),
    .run_o(run_o), .tc_o(tc_o), .kill_act_o(kill_act_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_prd = 0; m_cmp = 0; m_dt = 0; m_safe = 0; m_cnt = 0; m_capv = 0;
      m_len_t = 0; m_len_c = 0; m_run = 0; m_stop = 0; m_valid = 0;
      m_ovf = 0; m_killq = 1;
    end else begin
      bit raw, ctrl, ps, n_ovf;
      int d;
      d    = int'(wr_data_i);
      ctrl = wr_en_i && wr_addr_i == 3'd3;
      raw  = m_cnt < m_cmp;
      m_len_t = raw  ? ((m_len_t < 255) ? m_len_t + 1 : 255) : 0;
      m_len_c = !raw ? ((m_len_c < 255) ? m_len_c + 1 : 255) : 0;
      n_ovf   = !cap_rd_i && (m_ovf || (cap_evt_i && m_valid));
      m_valid = cap_evt_i || (m_valid && !cap_rd_i);
      m_ovf   = n_ovf;
      if (cap_evt_i) m_capv = m_cnt;
      ps = (ctrl && d[2]) || (!ctrl && m_run && m_cnt == m_prd && !m_stop);
      if (ctrl) begin
        if (d[2]) m_cnt = 0;
        m_run  = d[0];
        m_stop = d[1];
      end else if (m_run) begin
        if (m_cnt == m_prd) begin
          if (m_stop) m_run = 0; else m_cnt = 0;
        end else m_cnt = m_cnt + 1;
      end
      if (kill_i) m_killq = 1; else if (ps) m_killq = 0;
      if (wr_en_i) case (wr_addr_i)
        3'd0: m_prd = d;
        3'd1: m_cmp = d;
        3'd2: m_dt = d & 255;
        3'd4: m_safe = d & 3;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_ni && chk_en) begin
      bit raw, kill, et, ec;
      raw  = m_cnt < m_cmp;
      kill = kill_i || m_killq;
      et = kill ? m_safe[0] : (raw && m_len_t >= m_dt);
      ec = kill ? m_safe[1] : (!raw && m_len_c >= m_dt);
      chk("R2 count", int'(count_o), m_cnt);
      chk("R2 tc", int'(tc_o), int'(m_run && m_cnt == m_prd));
      chk("R3 run", int'(run_o), int'(m_run));
      chk("R4 cap_val", int'(cap_val_o), m_capv);
      chk("R4 cap_valid", int'(cap_valid_o), int'(m_valid));
      chk("R5 cap_ovf", int'(cap_ovf_o), int'(m_ovf));
      chk("R10 kill_act", int'(kill_act_o), int'(kill));
      chk(kill ? "R9 pwm" : "R7 pwm", int'(pwm_o), int'(et));
      chk(kill ? "R9 pwm_n" : "R7 pwm_n", int'(pwm_n_o), int'(ec));
      if (!kill_act_o) chk("R8 exclusive", int'(pwm_o && pwm_n_o), 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 16'(d);
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_cap(input bit rd);
    @(posedge clk); #1;
    if (rd) cap_rd_i = 1'b1; else cap_evt_i = 1'b1;
    @(posedge clk); #1;
    cap_rd_i = 1'b0; cap_evt_i = 1'b0;
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (int'(count_o) == v) break;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    chk_en = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 run", int'(run_o), 0);
    chk("R1 cap_valid", int'(cap_valid_o), 0);
    chk("R1 kill_act", int'(kill_act_o), 1);
    chk("R1 pwm pair", int'({pwm_o, pwm_n_o}), 0);

    wr(0, 9); wr(1, 4); wr(2, 2); wr(4, 0);
    wr(3, 3'b101);
    tick(30);

    // R6 duty with no dead time
    wr(2, 0);
    tick(2);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R6 duty", int'(pwm_o), int'(count_o < 16'd4));
    end

    // R4 / R5 capture
    pulse_cap(0);
    tick(1);
    pulse_cap(0);
    @(negedge clk);
    chk("R5 overflow set", int'(cap_ovf_o), 1);
    pulse_cap(1);
    @(negedge clk);
    chk("R4 read clears", int'({cap_valid_o, cap_ovf_o}), 0);

    // R6 compare above period
    wr(2, 2); wr(1, 20);
    tick(4);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R6 full duty", int'({pwm_o, pwm_n_o}), 2);
    end

    // R7 dead time variations
    wr(1, 5); wr(2, 3); tick(35);
    wr(2, 0); tick(20);
    wr(2, 7); tick(40);
    wr(1, 0); tick(15);
    wr(1, 5); wr(2, 1); tick(20);

    // R9 / R10 kill
    wr(4, 2'b10);
    wait_count(2);
    @(posedge clk); #1 kill_i = 1'b1;
    @(negedge clk);
    chk("R9 kill immediate", int'({pwm_n_o, pwm_o}), 2);
    tick(2);
    kill_i = 1'b0;
    @(negedge clk);
    chk("R10 held after release", int'(kill_act_o), 1);
    wait_count(0);
    chk("R10 released at wrap", int'(kill_act_o), 0);
    tick(10);
    // kill spanning a wrap
    @(posedge clk); #1 kill_i = 1'b1;
    tick(14);
    kill_i = 1'b0;
    tick(25);

    // R3 stop mode
    wr(3, 3'b111);
    tick(15);
    @(negedge clk);
    chk("R3 stop hold count", int'(count_o), 9);
    chk("R3 stop clears run", int'(run_o), 0);

    // R11 clear without run
    wr(3, 3'b100);
    @(negedge clk);
    chk("R11 clear count", int'(count_o), 0);
    chk("R11 run from bit0", int'(run_o), 0);
    tick(5);

    // R2 period zero
    wr(0, 0);
    wr(3, 3'b101);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 zero period tc", int'({tc_o, count_o}), 32'h10000);
    end
    wr(0, 3); wr(1, 2);
    pulse_cap(0); pulse_cap(0); pulse_cap(1);
    tick(20);

    finish_run();
  end
endmodule